// File: doc/BRIEF.md
# Per-Packet Receive Error Counter

This block keeps a 16-bit statistic for the receive side of a physical-layer transceiver. It counts received frames that held at least one receive error. It does not count error cycles. While a frame is active, the block watches the receive error flag and the collision flag and remembers whether each of them was raised. When the frame ends, it adds at most one to the count. A frame that saw a collision is treated as an invalid reception and is never counted.

Management logic reads the count through a simple address-decoded register port. A read returns the current value and empties the counter on the following clock edge, so each read reports the errored frames seen since the previous read. A write to the same address loads the counter with the written value. An increment that lands in the same cycle as a clearing read is kept, so no frame is lost between two reads.

Top module: `rx_err_pkt_counter`

## Requirements
- R1: After reset the counter holds 0x0000, and a read of the counter address returns 0x0000.
- R2: A frame with several receive-error cycles and no collision adds exactly one to the counter.
- R3: The increment takes effect on the clock edge where `rx_active` is first sampled low after being high (the end of the frame). A read while the frame is still active does not yet show it.
- R4: A frame in which `col` was high in any active cycle is not counted, whether the collision came before or after the error.
- R5: The counter wraps from 0xFFFF to 0x0000 on an increment.
- R6: A read (`reg_rd` high while `reg_addr` equals `CNT_ADDR`) returns the count in that cycle. The counter is 0x0000 from the next edge on.
- R7: When a clearing read and an end-of-frame increment fall in the same cycle, the read returns the old value and the counter becomes 0x0001.
- R8: A write (`reg_wr` high while `reg_addr` equals `CNT_ADDR`) loads `reg_wdata` into the counter. It takes priority over a read or an increment in the same cycle.
- R9: Reads and writes at any other address leave the counter unchanged. `reg_rdata` is 0x0000 whenever `reg_addr` differs from `CNT_ADDR`.
- R10: The error and collision history is cleared when a new frame starts, and is reloaded from that frame's first active cycle. The history of one frame does not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_active | input | 1 | High for every cycle of a frame being received |
| rx_err | input | 1 | Receive error seen in this cycle |
| col | input | 1 | Collision seen in this cycle |
| reg_addr | input | 5 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Counter value when the address matches, otherwise zero |

## Verification
A wrong error or collision flag inside the frame tracker cannot be seen until that frame ends. It then appears as a count one too high or too low at the next read of the counter. A wrong counter value appears at once on `reg_rdata` in the next read cycle. A missed clear shows up as a non-zero result when two reads are made back to back. The bench therefore follows every interesting frame with a read. This pins each defect to the frame that caused it.

// File: rtl/rxerr_cnt_pkg.sv
package rxerr_cnt_pkg;

    // Per-frame history kept by the tracker
    typedef struct packed {
        logic act;       // rx_active delayed by one cycle
        logic err_seen;  // an error was flagged in this frame
        logic col_seen;  // a collision was flagged in this frame
    } trk_state_t;

    // Register access decode result
    typedef struct packed {
        logic rd_hit;
        logic wr_hit;
        logic sel;
    } acc_t;

endpackage

// File: rtl/rxerr_frame_tracker.sv
module rxerr_frame_tracker
    import rxerr_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_active,
    input  logic rx_err,
    input  logic col,
    output logic commit_o
);

    trk_state_t st_d, st_q;
    logic       sof, eof;

    always_comb begin
        st_d     = st_q;
        sof      = rx_active & ~st_q.act;
        eof      = ~rx_active & st_q.act;
        st_d.act = rx_active;
        if (sof) begin
            st_d.err_seen = rx_err;
            st_d.col_seen = col;
        end else if (rx_active) begin
            st_d.err_seen = st_q.err_seen | rx_err;
            st_d.col_seen = st_q.col_seen | col;
        end
        commit_o = eof & st_q.err_seen & ~st_q.col_seen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: an increment is requested in one cycle only, never in two cycles back to back
    assert_one_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    // R4: a collision seen during an active cycle blocks the commit when the frame ends
    assert_col_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_active && col) |=> (rx_active || !commit_o));

    // R3: an increment is requested only when the frame has just finished
    assert_commit_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (!rx_active && $past(rx_active)));

endmodule

// File: rtl/rxerr_reg_decode.sv
module rxerr_reg_decode
    import rxerr_cnt_pkg::*;
#(
    parameter int          AW       = 5,
    parameter logic [AW-1:0] CNT_ADDR = 5'h15
) (
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    output acc_t          acc_o
);

    always_comb begin
        acc_o.sel    = (reg_addr == CNT_ADDR);
        acc_o.wr_hit = acc_o.sel & reg_wr;
        acc_o.rd_hit = acc_o.sel & reg_rd & ~reg_wr;
    end

endmodule

// File: rtl/rxerr_count_core.sv
module rxerr_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_i,
    input  logic         rd_hit_i,
    input  logic         wr_hit_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_hit_i)       cnt_d = wdata_i;
        else if (rd_hit_i)  cnt_d = commit_i ? ONE : '0;
        else if (commit_i)  cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R5: an increment steps the count by one and wraps modulo 2**W
    assert_step_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !rd_hit_i && !wr_hit_i) |=> (cnt_q == W'($past(cnt_q) + ONE)));

    // R6: a plain read empties the counter
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_i && !commit_i && !wr_hit_i) |=> (cnt_q == '0));

    // R7: an increment that coincides with a read is kept
    assert_read_keeps_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit_i && commit_i && !wr_hit_i) |=> (cnt_q == ONE));

    // R9: with no access and no increment the counter holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i && !rd_hit_i && !wr_hit_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rx_err_pkt_counter.sv
module rx_err_pkt_counter
    import rxerr_cnt_pkg::*;
#(
    parameter int              W        = 16,
    parameter int              AW       = 5,
    parameter logic [AW-1:0]   CNT_ADDR = 5'h15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_active,
    input  logic          rx_err,
    input  logic          col,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata
);

    logic         commit;
    acc_t         acc;
    logic [W-1:0] cnt;

    rxerr_frame_tracker i_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_active (rx_active),
        .rx_err    (rx_err),
        .col       (col),
        .commit_o  (commit)
    );

    rxerr_reg_decode #(.AW(AW), .CNT_ADDR(CNT_ADDR)) i_dec (
        .reg_addr (reg_addr),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .acc_o    (acc)
    );

    rxerr_count_core #(.W(W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .rd_hit_i (acc.rd_hit),
        .wr_hit_i (acc.wr_hit),
        .wdata_i  (reg_wdata),
        .cnt_o    (cnt)
    );

    assign reg_rdata = acc.sel ? cnt : '0;

    // R8: a matching write lands in the counter regardless of other events
    assert_write_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == CNT_ADDR) |=> (cnt == $past(reg_wdata)));

    // R9: a foreign address reads as zero
    assert_foreign_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != CNT_ADDR) |-> (reg_rdata == '0));

endmodule

// File: tb/test_rx_err_pkt_counter.sv
module test_rx_err_pkt_counter;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_CNT = 5'h15;
    localparam logic [4:0] A_OTH = 5'h16;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        rx_active = 0, rx_err = 0, col = 0;
    logic [4:0]  reg_addr = A_CNT;
    logic        reg_rd = 0, reg_wr = 0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_err_pkt_counter i_rx_err_pkt_counter (
        .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .rx_err(rx_err), .col(col),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // monitor: every read cycle pops one expectation
    always @(negedge clk) begin
        if (reg_rd) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL unexpected read: actual %h expected none", reg_rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (reg_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic do_read(input logic [4:0] a, input logic [15:0] e, input string t);
        @(posedge clk); #1;
        reg_addr = a; reg_rd = 1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        reg_rd = 0; reg_addr = A_CNT;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [15:0] v);
        @(posedge clk); #1;
        reg_addr = a; reg_wr = 1; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 0; reg_addr = A_CNT;
    endtask

    // frame of len cycles; err/col masks per cycle; optional access on the end cycle
    task automatic send_frame(input int len, input logic [31:0] em, input logic [31:0] cm,
                              input bit end_rd, input logic [15:0] end_exp,
                              input bit end_wr, input logic [15:0] end_wd, input string t);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            rx_active = 1; rx_err = em[i]; col = cm[i];
        end
        @(posedge clk); #1;
        rx_active = 0; rx_err = 0; col = 0;
        if (end_rd) begin
            reg_addr = A_CNT; reg_rd = 1;
            exp_q.push_back(end_exp); tag_q.push_back(t);
        end
        if (end_wr) begin
            reg_addr = A_CNT; reg_wr = 1; reg_wdata = end_wd;
        end
        if (end_rd || end_wr) begin
            @(posedge clk); #1;
            reg_rd = 0; reg_wr = 0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        do_read(A_CNT, 16'h0000, "R1 reset value");

        send_frame(5, 32'b01110, 0, 0, 0, 0, 0, "");
        do_read(A_CNT, 16'h0001, "R2 many errors count once");
        do_read(A_CNT, 16'h0000, "R6 second read after clear");

        send_frame(4, 0, 0, 0, 0, 0, 0, "");
        do_read(A_CNT, 16'h0000, "R2 clean frame not counted");

        send_frame(6, 32'b000010, 32'b001000, 0, 0, 0, 0, "");
        do_read(A_CNT, 16'h0000, "R4 collision after error");
        send_frame(6, 32'b100000, 32'b000001, 0, 0, 0, 0, "");
        do_read(A_CNT, 16'h0000, "R4 collision before error");

        // R3: read mid-frame sees nothing yet
        @(posedge clk); #1; rx_active = 1; rx_err = 1;
        @(posedge clk); #1; rx_err = 0;
        reg_addr = A_CNT; reg_rd = 1;
        exp_q.push_back(16'h0000); tag_q.push_back("R3 no count before frame end");
        @(posedge clk); #1; reg_rd = 0;
        @(posedge clk); #1; rx_active = 0;
        do_read(A_CNT, 16'h0001, "R3 count after frame end");

        // R10: history does not carry over
        send_frame(3, 32'b001, 0, 0, 0, 0, 0, "");
        send_frame(3, 0, 0, 0, 0, 0, 0, "");
        do_read(A_CNT, 16'h0001, "R10 error history cleared at new frame");
        send_frame(3, 0, 32'b010, 0, 0, 0, 0, "");
        send_frame(3, 32'b001, 0, 0, 0, 0, 0, "");
        do_read(A_CNT, 16'h0001, "R10 collision history cleared, error on first cycle");

        do_write(A_CNT, 16'h1234);
        do_read(A_CNT, 16'h1234, "R8 write loads value");

        do_write(A_OTH, 16'h0055);
        do_write(A_CNT, 16'h0007);
        do_read(A_OTH, 16'h0000, "R9 foreign address reads zero");
        do_read(A_CNT, 16'h0007, "R9 foreign read and write leave count");

        do_write(A_CNT, 16'hFFFF);
        send_frame(2, 32'b10, 0, 0, 0, 0, 0, "");
        do_read(A_CNT, 16'h0000, "R5 wrap to zero");
        do_write(A_CNT, 16'hFFFE);
        send_frame(2, 32'b01, 0, 0, 0, 0, 0, "");
        do_read(A_CNT, 16'hFFFF, "R5 step to top value");

        do_write(A_CNT, 16'h0005);
        send_frame(3, 32'b010, 0, 1, 16'h0005, 0, 0, "R7 read on frame end returns old");
        do_read(A_CNT, 16'h0001, "R7 coinciding increment kept");

        send_frame(3, 32'b100, 0, 0, 0, 1, 16'h0100, "");
        do_read(A_CNT, 16'h0100, "R8 write wins over increment");

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R6 pending reads: actual %0d expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule